// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Registers

This block keeps the time of day and the calendar in packed BCD, 24-hour form: seconds, minutes, hours, day of week, date, month, year and century. It advances once for each accepted pulse on a one-pulse-per-second tick input. It also emits a one-cycle pulse on every update, so that alarm logic can compare against fresh values.

The block holds two copies of the time. The running counters are internal. A bus-visible shadow copy sits in front of them and is read and written through a simple synchronous port at addresses 0 to 7. A transfer-enable input controls how the two copies interact. While it is high, the shadow tracks the counters, and bus writes go straight into the counters. While it is low, the shadow is frozen. This lets software read a coherent snapshot or stage a complete new time. When the input goes high again, the staged values are copied into the counters in one step.

Bit 7 of the month register stops the clock. While it is set, ticks are ignored.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00, day 01, date 01, month 01 (with bits 7 to 5 cleared), year 00 and century 00.
- R2: The address map is: 0 seconds (00–59), 1 minutes (00–59), 2 hours (00–23), 3 day of week (1–7), 4 date (01–31), 5 month (01–12 in bits 4:0), 6 year (00–99), 7 century (00–39). All values are packed BCD, with the tens digit in bits 7:4 and the ones digit in bits 3:0.
- R3: Bits outside each field always read 0, and writes to them have no effect. The widths are: seconds and minutes use 7 bits, hours, date and century use 6, day uses 3, and year uses 8. In the month register, bits 7 to 5 are stored and read back as written.
- R4: While transfer-enable is 0, the shadow copy does not change except through bus writes. Reads return those frozen values even when ticks arrive, and writes land only in the shadow.
- R5: On the first cycle in which transfer-enable is 1 after being 0, the shadow values are loaded into the counters. The shadow shows the loaded values from the following cycle on.
- R6: While transfer-enable stays 1, the shadow copies the counters every cycle, lagging by one cycle. A bus write in that state goes directly into the addressed counter.
- R7: Seconds and minutes wrap from 59 to 00, and each wrap carries into the next field. Hours wrap from 23 to 00.
- R8: Each hour wrap also advances the day of week, which wraps from 7 to 1.
- R9: After the last date of a month, the date returns to 01 and the month advances. The last date is 30 for months 04, 06, 09 and 11, and 31 for all other months except 02. For month 02 it is 29 when the two-digit year is divisible by 4, and 28 otherwise.
- R10: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and advances the century. The century wraps from 39 to 00.
- R11: While month bit 7 is 1, ticks are ignored and no field changes. Writing it back to 0 lets counting resume.
- R12: The update pulse output is high for exactly the one cycle after an accepted tick. A tick is not accepted while the clock is stopped, or in a cycle that has a bus write or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| xfer_en_i | input | 1 | Transfer enable: 1 = shadow tracks counters, 0 = shadow frozen |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the shadow copy (combinational on addr_i) |
| sec_pulse_o | output | 1 | One-cycle pulse on each accepted update |

## Verification
The carry chain is tested in three ways:
- A run of two hundred consecutive ticks starting just before a minute and an hour boundary is compared tick by tick against arithmetic counters in the bench. This separates the ones-digit carry from the field wraps.
- A sweep through the last second of every month of a common year, a leap year and year 00 tells apart each entry of the month-length table and the leap rule.
- Targeted starts at midnight on day 7, at the end of year 99 and at century 39 isolate the day-of-week wrap and the upper carries.

The shadow behaviour is tested with ticks and writes while transfer is off, showing the frozen values on reads, and then with the reload edge. The stop bit is tested by ticking with it set and then cleared.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 8;
  localparam int AW     = $clog2(NREG);

  typedef struct packed {
    logic [DW-1:0] cen;
    logic [DW-1:0] yr;
    logic [DW-1:0] mon;
    logic [DW-1:0] date;
    logic [DW-1:0] day;
    logic [DW-1:0] hr;
    logic [DW-1:0] min;
    logic [DW-1:0] sec;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{cen: 8'h00, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                      day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [DW-1:0] reg_mask(input logic [AW-1:0] a);
    case (a)
      3'd0, 3'd1: return 8'h7F;
      3'd2, 3'd4, 3'd7: return 8'h3F;
      3'd3: return 8'h07;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_leap(input logic [DW-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [DW-1:0] month_last(input logic [4:0] m, input logic [DW-1:0] y);
    case (m)
      5'h02: return is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] first_i,
  input  logic [W-1:0] last_i,
  input  logic         en_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic [W-1:0] inc;

  always_comb begin
    if (val_i[3:0] >= 4'd9) inc = {val_i[W-1:4] + 1'b1, 4'h0};
    else                    inc = val_i + 1'b1;
  end

  // at-or-beyond top wraps, so out-of-range loads recover
  assign wrap_o = en_i && (val_i >= last_i);
  assign nxt_o  = !en_i ? val_i : (wrap_o ? first_i : inc);
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  cal_time_t     ld_val_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output cal_time_t     cur_o,
  output logic          pulse_o
);
  cal_time_t cur_q, nxt;
  logic adv, stop;
  logic s_w, m_w, h_w, dt_w, mo_w, y_w;
  logic [DW-1:0] s_n, m_n, h_n, dy_n, dt_n, y_n, c_n;
  logic [4:0] mo_n;
  logic dy_w_unused;

  assign stop = cur_q.mon[7];
  assign adv  = tick_i && !stop && !load_i && !wr_i;

  cal_bcd_step #(.W(DW)) u_sec (.val_i(cur_q.sec), .first_i(8'h00), .last_i(8'h59),
    .en_i(adv), .nxt_o(s_n), .wrap_o(s_w));
  cal_bcd_step #(.W(DW)) u_min (.val_i(cur_q.min), .first_i(8'h00), .last_i(8'h59),
    .en_i(s_w), .nxt_o(m_n), .wrap_o(m_w));
  cal_bcd_step #(.W(DW)) u_hr (.val_i(cur_q.hr), .first_i(8'h00), .last_i(8'h23),
    .en_i(m_w), .nxt_o(h_n), .wrap_o(h_w));
  cal_bcd_step #(.W(DW)) u_day (.val_i(cur_q.day), .first_i(8'h01), .last_i(8'h07),
    .en_i(h_w), .nxt_o(dy_n), .wrap_o(dy_w_unused));
  cal_bcd_step #(.W(DW)) u_date (.val_i(cur_q.date), .first_i(8'h01),
    .last_i(month_last(cur_q.mon[4:0], cur_q.yr)),
    .en_i(h_w), .nxt_o(dt_n), .wrap_o(dt_w));
  cal_bcd_step #(.W(5)) u_mon (.val_i(cur_q.mon[4:0]), .first_i(5'h01), .last_i(5'h12),
    .en_i(dt_w), .nxt_o(mo_n), .wrap_o(mo_w));
  cal_bcd_step #(.W(DW)) u_yr (.val_i(cur_q.yr), .first_i(8'h00), .last_i(8'h99),
    .en_i(mo_w), .nxt_o(y_n), .wrap_o(y_w));

  always_comb begin
    if (!y_w)                    c_n = cur_q.cen;
    else if (cur_q.cen >= 8'h39) c_n = 8'h00;
    else if (cur_q.cen[3:0] >= 4'd9) c_n = {cur_q.cen[7:4] + 4'd1, 4'h0};
    else                         c_n = cur_q.cen + 8'd1;
  end

  always_comb begin
    nxt      = cur_q;
    nxt.sec  = s_n;
    nxt.min  = m_n;
    nxt.hr   = h_n;
    nxt.day  = dy_n;
    nxt.date = dt_n;
    nxt.mon  = {cur_q.mon[7:5], mo_n};
    nxt.yr   = y_n;
    nxt.cen  = c_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= CAL_RESET;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= adv;
      if (load_i)    cur_q <= ld_val_i;
      else if (wr_i) cur_q[{addr_i, 3'b000} +: DW] <= wdata_i & reg_mask(addr_i);
      else if (adv)  cur_q <= nxt;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/cal_shadow_regs.sv
module cal_shadow_regs
  import cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          follow_i,
  input  cal_time_t     cur_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output cal_time_t     ext_o
);
  cal_time_t ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ext_q <= CAL_RESET;
    else if (wr_i)     ext_q[{addr_i, 3'b000} +: DW] <= wdata_i & reg_mask(addr_i);
    else if (follow_i) ext_q <= cur_i;
  end

  assign ext_o = ext_q;
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          xfer_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sec_pulse_o
);
  cal_time_t cur_t, ext_t;
  logic te_q, load, follow, wr_int, wr_ext, osc_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) te_q <= 1'b1;
    else         te_q <= xfer_en_i;
  end

  assign load     = xfer_en_i && !te_q;
  assign follow   = xfer_en_i && te_q;
  assign wr_int   = wr_en_i && xfer_en_i;
  assign wr_ext   = wr_en_i && !xfer_en_i;
  assign osc_stop = cur_t.mon[7];

  cal_time_core u_core (
    .clk_i, .rst_ni, .tick_i,
    .load_i(load), .ld_val_i(ext_t),
    .wr_i(wr_int), .addr_i, .wdata_i,
    .cur_o(cur_t), .pulse_o(sec_pulse_o)
  );

  cal_shadow_regs u_shadow (
    .clk_i, .rst_ni,
    .follow_i(follow), .cur_i(cur_t),
    .wr_i(wr_ext), .addr_i, .wdata_i,
    .ext_o(ext_t)
  );

  assign rdata_o = ext_t[{addr_i, 3'b000} +: DW];
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       xfer_en_i,
  input logic       wr_en_i,
  input logic [2:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       sec_pulse_o,
  input logic       te_q,
  input logic       load,
  input logic       osc_stop,
  input logic [7:0] cur_sec,
  input logic [7:0] ext_sec
);
  assert_pulse_needs_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |-> ($past(tick_i) && !$past(osc_stop)));

  assert_stop_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stop |=> !sec_pulse_o);

  assert_load_copies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cur_sec == $past(ext_sec)));

  assert_frozen_shadow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_en_i && !wr_en_i) |=> $stable(ext_sec));

  assert_shadow_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_en_i && te_q && !wr_en_i) |=> (ext_sec == $past(cur_sec)));

  assert_unused_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd3) |-> (rdata_o[7:3] == 5'd0));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .xfer_en_i(xfer_en_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .sec_pulse_o(sec_pulse_o),
  .te_q(te_q), .load(load), .osc_stop(osc_stop),
  .cur_sec(cur_t.sec), .ext_sec(ext_t.sec)
);

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       te = 1'b1;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pulse;

  int errors = 0;
  int checks = 0;
  int e_s, e_m, e_h, e_dy, e_dt, e_mo, e_y, e_c;

  always #5 clk = ~clk;

  bcd_calendar_clock uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .xfer_en_i(te), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sec_pulse_o(pulse)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    case (a)
      0: return to_bcd(e_s);
      1: return to_bcd(e_m);
      2: return to_bcd(e_h);
      3: return to_bcd(e_dy);
      4: return to_bcd(e_dt);
      5: return to_bcd(e_mo);
      6: return to_bcd(e_y);
      default: return to_bcd(e_c);
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = 3'(a);
    #1 v = rdata;
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 3'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check(req, v, exp_reg(a));
    end
  endtask

  task automatic set_time(input int s, input int m, input int h, input int dy,
                          input int dt, input int mo, input int y, input int c);
    @(negedge clk); te = 1'b0;
    wr_reg(0, to_bcd(s)); wr_reg(1, to_bcd(m)); wr_reg(2, to_bcd(h)); wr_reg(3, to_bcd(dy));
    wr_reg(4, to_bcd(dt)); wr_reg(5, to_bcd(mo)); wr_reg(6, to_bcd(y)); wr_reg(7, to_bcd(c));
    @(negedge clk); te = 1'b1;
    @(negedge clk); @(negedge clk);
    e_s = s; e_m = m; e_h = h; e_dy = dy; e_dt = dt; e_mo = mo; e_y = y; e_c = c;
  endtask

  task automatic model_tick();
    e_s++;
    if (e_s == 60) begin
      e_s = 0; e_m++;
      if (e_m == 60) begin
        e_m = 0; e_h++;
        if (e_h == 24) begin
          e_h = 0;
          e_dy = (e_dy == 7) ? 1 : e_dy + 1;
          e_dt++;
          if (e_dt > days_in(e_mo, e_y)) begin
            e_dt = 1; e_mo++;
            if (e_mo == 13) begin
              e_mo = 1; e_y++;
              if (e_y == 100) begin
                e_y = 0;
                e_c = (e_c == 39) ? 0 : e_c + 1;
              end
            end
          end
        end
      end
    end
  endtask

  // tick for one cycle; pulse must be high one cycle after, then low (R12)
  task automatic tick_once(input logic expect_adv);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R12 pulse", {7'd0, pulse}, {7'd0, expect_adv});
    @(negedge clk);
    check("R12 pulse width", {7'd0, pulse}, 8'd0);
    if (expect_adv) model_tick();
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_s = 0; e_m = 0; e_h = 0; e_dy = 1; e_dt = 1; e_mo = 1; e_y = 0; e_c = 0;
    check_all("R1 reset");
    check("R12 idle", {7'd0, pulse}, 8'd0);

    // R3 masks, staged with transfer off
    @(negedge clk); te = 1'b0;
    wr_reg(0, 8'hFF); rd(0, v); check("R3 sec mask", v, 8'h7F);
    wr_reg(1, 8'hFF); rd(1, v); check("R3 min mask", v, 8'h7F);
    wr_reg(2, 8'hFF); rd(2, v); check("R3 hr mask", v, 8'h3F);
    wr_reg(3, 8'hFF); rd(3, v); check("R3 day mask", v, 8'h07);
    wr_reg(4, 8'hFF); rd(4, v); check("R3 date mask", v, 8'h3F);
    wr_reg(5, 8'h65); rd(5, v); check("R3 month ctl bits", v, 8'h65);
    wr_reg(6, 8'hFF); rd(6, v); check("R3 year full", v, 8'hFF);
    wr_reg(7, 8'hFF); rd(7, v); check("R3 cen mask", v, 8'h3F);

    // R2 map and R5 load
    set_time(56, 34, 12, 3, 15, 6, 21, 20);
    check_all("R2 R5 load");

    // R4 frozen copy
    @(negedge clk); te = 1'b0;
    tick_once(1'b1);
    tick_once(1'b1);
    rd(0, v); check("R4 frozen sec", v, 8'h56);
    wr_reg(0, 8'h10); rd(0, v); check("R4 write shadow", v, 8'h10);
    rd(1, v); check("R4 frozen min", v, 8'h34);
    @(negedge clk); te = 1'b1;
    @(negedge clk); @(negedge clk);
    e_s = 10; e_m = 34;
    check_all("R5 reload");

    // R7 sweep across minute and hour boundaries
    set_time(30, 58, 12, 5, 10, 3, 22, 20);
    for (int i = 0; i < 200; i++) begin
      tick_once(1'b1);
      rd(0, v); check("R7 sec", v, exp_reg(0));
      rd(1, v); check("R7 min", v, exp_reg(1));
      rd(2, v); check("R7 hr", v, exp_reg(2));
    end

    // R7 R8 midnight with day 7
    set_time(59, 59, 23, 7, 15, 5, 30, 20);
    tick_once(1'b1);
    check_all("R8 midnight");
    rd(3, v); check("R8 day wrap", v, 8'h01);

    // R9 month ends for common, leap and year 00
    for (int yi = 0; yi < 3; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        int y;
        y = (yi == 0) ? 23 : ((yi == 1) ? 24 : 0);
        set_time(59, 59, 23, 2, days_in(mo, y), mo, y, 20);
        tick_once(1'b1);
        check_all("R9 month end");
        rd(4, v); check("R9 date 01", v, 8'h01);
      end
    end
    // R9 Feb 28 in leap year goes to 29
    set_time(59, 59, 23, 2, 28, 2, 24, 20);
    tick_once(1'b1);
    rd(4, v); check("R9 leap 29", v, 8'h29);

    // R10 year and century
    set_time(59, 59, 23, 4, 31, 12, 99, 19);
    tick_once(1'b1);
    check_all("R10 year wrap");
    rd(7, v); check("R10 cen carry", v, 8'h20);
    set_time(59, 59, 23, 4, 31, 12, 99, 39);
    tick_once(1'b1);
    rd(7, v); check("R10 cen wrap", v, 8'h00);
    rd(5, v); check("R10 month wrap", v, 8'h01);

    // R6 direct write and follow
    set_time(0, 0, 8, 1, 1, 1, 50, 20);
    wr_reg(0, 8'h30);
    @(negedge clk);
    e_s = 30;
    rd(0, v); check("R6 direct write", v, 8'h30);
    tick_once(1'b1);
    rd(0, v); check("R6 follow", v, 8'h31);

    // R11 stop bit
    wr_reg(5, 8'h81);
    @(negedge clk);
    rd(5, v); check("R11 stop bit reads", v, 8'h81);
    tick_once(1'b0);
    tick_once(1'b0);
    rd(0, v); check("R11 halted", v, 8'h31);
    wr_reg(5, 8'h01);
    @(negedge clk);
    tick_once(1'b1);
    rd(0, v); check("R11 resumed", v, 8'h32);
    check_all("R11 all");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule